// File: doc/BRIEF.md
# EDID Register-Mapped I2C Responder

This block stands in for a display I2C bus controller, seen from the host through four 32-bit registers. It does not drive any I2C pins. Register accesses alone move a bus phase through idle, data and wait. The block answers queries for the monitor identification data (EDID) from a local 128-byte ROM. The ROM contents come from a parameter. A host driver writes the pin-select register, then issues a command that names the target device, the byte count and the cycle type. It then reads the data register repeatedly, and each read yields up to four EDID bytes.

The block has no bus timing. A stop cycle goes straight to idle. A transfer closes on the data read that consumes the last bytes of the programmed count. One monitor is modelled, through a presence input and a flag that marks a DisplayPort-type sink.

Top module: `edid_resp`

## Requirements
- R1: Register addresses: 0 pin select, 1 command, 2 status, 3 data. A read returns its value on `rdata` one cycle after `rd_en`. A write takes priority over a read in the same cycle, and `rdata` changes only on a read. After reset every register is 0 and the phase is idle. Phase codes: 0 idle, 1 data, 2 wait.
- R2: Command fields: bit 0 requests a read, bits 7:1 are the 7-bit target, bits 15:8 the index, bits 24:16 the 9-bit byte count, bits 27:25 the cycle type and bit 30 the clear-interrupt request. Only target 0x50 selects the responder. Any other target leaves it unselected.
- R3: When command bit 25 (index flag) is set, the read pointer is loaded from the index field, clamped to 128.
- R4: Cycle codes 010, 011, 110 and 111 start a transfer. Each sets the phase to data and sets status bit 1 (active).
- R5: Cycle code 100 (stop) clears the responder state, sets the phase to idle and clears active. It does so only when the stored cycle type is not 000; otherwise it has no effect.
- R6: A data read, while the stored command requests a read and remaining = count - pointer is above 0, fetches min(4, remaining) bytes. They are packed little-endian with the first byte in bits 7:0. Bytes beyond that keep their previous value. Each byte delivered from the ROM advances the pointer by one.
- R7: When such a read finds 4 or fewer bytes remaining, the transfer closes. The phase goes to idle if cycle bit 27 is set and to wait otherwise, and selection, EDID availability, pointer and count are cleared.
- R8: Any pin-select write clears the responder state and sets the phase to idle. A nonzero value in bits 2:0 also clears active and sets status bit 0 (ready) and bit 4 (wait). It then makes EDID available and clears status bit 2 (no-acknowledge) when a monitor is present and is not DisplayPort-type. Otherwise it sets bit 2.
- R9: A status read returns the old value and then sets bit 3 (in use). Writing 1 to bit 3 clears it. All other status bits ignore writes.
- R10: A command write with bit 30 set sets ready. While the stored bit 30 is set, command writes that keep bit 30 are ignored. The next command write with bit 30 clear resets the controller: status becomes ready, plus no-acknowledge if no EDID is available, and the phase becomes idle.
- R11: Bytes fetched without selection and availability, or at pointer 128 or above, read as 0 and do not advance the pointer.
- R12: Data-register writes are ignored. A data read without a pending read transfer returns the stored data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| mon_present | input | 1 | Monitor attached |
| mon_is_dp | input | 1 | Attached monitor is DisplayPort-type |
| rdata | output | 32 | Registered read data |
| bus_phase | output | 2 | Current bus phase |

## Verification
The bench builds the block with four bytes per data read and target 0x50. Its ROM pattern gives every byte a value different from its neighbours and from its own address. A swapped lane, a lane that fails to retain its old byte, or a pointer that is off by one therefore shows up in the packed word. Indexing to byte 126 brings the end of the 128-byte ROM within a single read, so the zero fill and the stalled pointer are both exercised.

// File: rtl/edid_resp_pkg.sv
`timescale 1ns/1ps
package edid_resp_pkg;
  localparam int EDID_BYTES = 128;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_DATA = 2'd1, PH_WAIT = 2'd2} phase_e;

  localparam logic [1:0] A_PIN  = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  localparam int ST_READY  = 0;
  localparam int ST_ACTIVE = 1;
  localparam int ST_NAK    = 2;
  localparam int ST_INUSE  = 3;
  localparam int ST_WAIT   = 4;

  localparam int C_DIR    = 0;
  localparam int C_CLRINT = 30;
  localparam int C_SWRDY  = 31;

  function automatic logic [EDID_BYTES*8-1:0] rom_pattern();
    logic [EDID_BYTES*8-1:0] r;
    for (int i = 0; i < EDID_BYTES; i++) r[i*8 +: 8] = 8'(i * 5 + 17);
    return r;
  endfunction
endpackage

// File: rtl/edid_resp_rom.sv
`timescale 1ns/1ps
module edid_resp_rom
  import edid_resp_pkg::*;
#(
  parameter int LANES = 4,
  parameter logic [EDID_BYTES*8-1:0] ROM_INIT = rom_pattern()
) (
  input  logic [$clog2(EDID_BYTES):0] base,
  input  logic                        en,
  output logic [LANES-1:0][7:0]       bytes,
  output logic [LANES-1:0]            in_rng
);
  localparam int AW = $clog2(EDID_BYTES);

  logic [7:0] rom_arr [EDID_BYTES];

  for (genvar b = 0; b < EDID_BYTES; b++) begin : g_rom
    assign rom_arr[b] = ROM_INIT[b*8 +: 8];
  end

  // one fetch lane per byte of a data-register read
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW+1:0] idx;
    assign idx       = {1'b0, base} + (AW+2)'(l);
    assign in_rng[l] = en && (idx < (AW+2)'(EDID_BYTES));
    assign bytes[l]  = in_rng[l] ? rom_arr[idx[AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/edid_resp_pack.sv
`timescale 1ns/1ps
module edid_resp_pack #(
  parameter int LANES = 4,
  parameter int CNT_W = 9,
  parameter int PTR_W = 8
) (
  input  logic signed [CNT_W:0]   left,
  input  logic [LANES-1:0][7:0]   bytes,
  input  logic [LANES-1:0]        in_rng,
  input  logic [31:0]             old_data,
  output logic [31:0]             new_data,
  output logic [PTR_W-1:0]        adv,
  output logic                    last
);
  logic [LANES-1:0] used;

  for (genvar l = 0; l < 4; l++) begin : g_byte
    if (l < LANES) begin : g_live
      assign used[l] = left > l;
      assign new_data[l*8 +: 8] = used[l] ? bytes[l] : old_data[l*8 +: 8];
    end else begin : g_keep
      assign new_data[l*8 +: 8] = old_data[l*8 +: 8];
    end
  end

  always_comb begin
    adv = '0;
    for (int l = 0; l < LANES; l++)
      if (used[l] && in_rng[l]) adv = adv + PTR_W'(1);
  end

  assign last = left <= LANES;
endmodule

// File: rtl/edid_resp.sv
`timescale 1ns/1ps
module edid_resp
  import edid_resp_pkg::*;
#(
  parameter int          LANES       = 4,
  parameter int          CNT_W       = 9,
  parameter logic [6:0]  TARGET_ADDR = 7'h50,
  parameter logic [EDID_BYTES*8-1:0] ROM_INIT = rom_pattern()
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic        mon_present,
  input  logic        mon_is_dp,
  output logic [31:0] rdata,
  output logic [1:0]  bus_phase
);
  localparam int PTR_W = $clog2(EDID_BYTES) + 1;

  logic [31:0]      pin_q, pin_d, cmd_q, cmd_d, stat_q, stat_d;
  logic [31:0]      data_q, data_d, rdata_q, rdata_d;
  phase_e           phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d, av_q, av_d;
  logic             acc_en;

  logic signed [CNT_W:0] left;
  logic [LANES-1:0][7:0] lane_bytes;
  logic [LANES-1:0]      lane_ok;
  logic [31:0]           packed_data;
  logic [PTR_W-1:0]      adv;
  logic                  last;

  assign left = $signed({1'b0, cnt_q}) - $signed((CNT_W+1)'(ptr_q));

  edid_resp_rom #(.LANES(LANES), .ROM_INIT(ROM_INIT)) u_rom (
    .base(ptr_q), .en(sel_q && av_q), .bytes(lane_bytes), .in_rng(lane_ok)
  );

  edid_resp_pack #(.LANES(LANES), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_pack (
    .left(left), .bytes(lane_bytes), .in_rng(lane_ok), .old_data(data_q),
    .new_data(packed_data), .adv(adv), .last(last)
  );

  always_comb begin
    pin_d = pin_q;   cmd_d = cmd_q;   stat_d = stat_q;  data_d = data_q;
    rdata_d = rdata_q; phase_d = phase_q; ptr_d = ptr_q; cnt_d = cnt_q;
    sel_d = sel_q;   av_d = av_q;
    if (wr_en) begin
      unique case (addr)
        A_PIN: begin
          pin_d = wdata;
          sel_d = 1'b0; ptr_d = '0; cnt_d = '0; av_d = 1'b0;
          phase_d = PH_IDLE;
          if (wdata[2:0] != 3'd0) begin
            stat_d[ST_ACTIVE] = 1'b0;
            stat_d[ST_READY]  = 1'b1;
            stat_d[ST_WAIT]   = 1'b1;
            av_d              = mon_present && !mon_is_dp;
            stat_d[ST_NAK]    = !(mon_present && !mon_is_dp);
          end
        end
        A_CMD: begin
          if (cmd_q[C_CLRINT]) begin
            if (!wdata[C_CLRINT]) begin
              cmd_d[C_CLRINT] = 1'b0;
              stat_d           = '0;
              stat_d[ST_READY] = 1'b1;
              stat_d[ST_NAK]   = !av_q;
              phase_d          = PH_IDLE;
            end
          end else begin
            if (wdata[C_CLRINT]) stat_d[ST_READY] = 1'b1;
            cnt_d = wdata[24:16];
            if (wdata[7:1] == TARGET_ADDR) sel_d = 1'b1;
            if (wdata[25])
              ptr_d = (wdata[15:8] > 8'(EDID_BYTES)) ? PTR_W'(EDID_BYTES) : PTR_W'(wdata[15:8]);
            if (wdata[27:25] == 3'b100) begin
              if (cmd_q[27:25] != 3'b000) begin
                sel_d = 1'b0; av_d = 1'b0; ptr_d = '0; cnt_d = '0;
                phase_d = PH_IDLE;
                stat_d[ST_ACTIVE] = 1'b0;
              end
            end else if (wdata[26]) begin
              phase_d = PH_DATA;
              stat_d[ST_ACTIVE] = 1'b1;
            end
            cmd_d = wdata;
            cmd_d[C_SWRDY] = 1'b0;
          end
        end
        A_STAT: if (wdata[ST_INUSE]) stat_d[ST_INUSE] = 1'b0;
        default: ;
      endcase
    end else if (rd_en) begin
      unique case (addr)
        A_PIN: rdata_d = pin_q;
        A_CMD: rdata_d = cmd_q;
        A_STAT: begin
          rdata_d = stat_q;
          stat_d[ST_INUSE] = 1'b1;
        end
        default: begin
          if (cmd_q[C_DIR] && (left > 0)) begin
            data_d  = packed_data;
            rdata_d = packed_data;
            ptr_d   = ptr_q + adv;
            if (last) begin
              phase_d = cmd_q[27] ? PH_IDLE : PH_WAIT;
              sel_d = 1'b0; av_d = 1'b0; ptr_d = '0; cnt_d = '0;
            end
          end else begin
            rdata_d = data_q;
          end
        end
      endcase
    end
  end

  assign acc_en = wr_en || rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0; cmd_q <= '0; stat_q <= '0; data_q <= '0; rdata_q <= '0;
      phase_q <= PH_IDLE; ptr_q <= '0; cnt_q <= '0; sel_q <= 1'b0; av_q <= 1'b0;
    end else if (acc_en) begin
      pin_q <= pin_d; cmd_q <= cmd_d; stat_q <= stat_d; data_q <= data_d;
      rdata_q <= rdata_d; phase_q <= phase_d; ptr_q <= ptr_d; cnt_q <= cnt_d;
      sel_q <= sel_d; av_q <= av_d;
    end
  end

  assign rdata     = rdata_q;
  assign bus_phase = phase_q;
endmodule

// File: rtl/edid_resp_chk.sv
`timescale 1ns/1ps
module edid_resp_chk #(
  parameter int LANES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [1:0]  bus_phase,
  input logic [31:0] stat_q,
  input logic [31:0] data_q,
  input logic [7:0]  ptr_q
);
  // R4
  phase_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_phase == 2'd1 |-> stat_q[1]);

  // R9
  inuse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd2 && wdata[3] |=> !stat_q[3]);

  // R9
  inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == 2'd2 |=> stat_q[3] && rdata == $past(stat_q));

  // R8
  pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 |=> bus_phase == 2'd0);

  // R12
  data_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd3 |=> $stable(data_q) && $stable(ptr_q) && $stable(rdata));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && addr == 2'd3 |=>
      (ptr_q == 8'd0) || (ptr_q >= $past(ptr_q) && (ptr_q - $past(ptr_q)) <= 8'(LANES)));

  // R11
  ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= 8'd128);
endmodule

bind edid_resp edid_resp_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .bus_phase(bus_phase), .stat_q(stat_q),
  .data_q(data_q), .ptr_q(ptr_q)
);

// File: tb/edid_resp_bench.sv
`timescale 1ns/1ps
module edid_resp_bench;
  function automatic logic [7:0] rb(int i);
    return 8'((i * 7 + 3) & 255) ^ 8'h5A;
  endfunction

  function automatic logic [1023:0] mk_rom();
    logic [1023:0] r;
    for (int i = 0; i < 128; i++) r[i*8 +: 8] = rb(i);
    return r;
  endfunction

  localparam logic [1023:0] ROM = mk_rom();

  function automatic logic [31:0] mkcmd(bit rdb, logic [6:0] t, logic [7:0] idx,
                                        logic [8:0] cnt, logic [2:0] cyc, bit clr);
    return {1'b0, clr, 2'b00, cyc, cnt, idx, t, rdb};
  endfunction

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, mon_present, mon_is_dp;
  logic [1:0] addr;
  logic [31:0] wdata, rdata;
  logic [1:0] bus_phase;

  always #4 clk = ~clk;

  edid_resp #(.LANES(4), .CNT_W(9), .TARGET_ADDR(7'h50), .ROM_INIT(ROM)) u_edid_resp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .mon_present(mon_present), .mon_is_dp(mon_is_dp),
    .rdata(rdata), .bus_phase(bus_phase)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_pin, m_cmd, m_stat, m_data, m_rdata;
  int m_phase, m_ptr, m_cnt;
  bit m_sel, m_av;

  task automatic m_drop();
    m_sel = 0; m_av = 0; m_ptr = 0; m_cnt = 0;
  endtask

  task automatic m_step();
    int left, n;
    logic [7:0] bt;
    if (wr_en) begin
      case (addr)
        2'd0: begin
          m_pin = wdata; m_drop(); m_phase = 0;
          if (wdata[2:0] != 0) begin
            m_stat[1] = 0; m_stat[0] = 1; m_stat[4] = 1;
            if (mon_present && !mon_is_dp) begin m_av = 1; m_stat[2] = 0; end
            else m_stat[2] = 1;
          end
        end
        2'd1: begin
          if (m_cmd[30]) begin
            if (!wdata[30]) begin
              m_cmd[30] = 0; m_stat = m_av ? 32'h1 : 32'h5; m_phase = 0;
            end
          end else begin
            if (wdata[30]) m_stat[0] = 1;
            m_cnt = int'(wdata[24:16]);
            if (wdata[7:1] == 7'h50) m_sel = 1;
            if (wdata[25]) m_ptr = (wdata[15:8] > 128) ? 128 : int'(wdata[15:8]);
            if (wdata[27:25] == 3'b100) begin
              if (m_cmd[27:25] != 0) begin m_drop(); m_phase = 0; m_stat[1] = 0; end
            end else if (wdata[26]) begin
              m_phase = 1; m_stat[1] = 1;
            end
            m_cmd = wdata; m_cmd[31] = 0;
          end
        end
        2'd2: if (wdata[3]) m_stat[3] = 0;
        default: ;
      endcase
    end else if (rd_en) begin
      case (addr)
        2'd0: m_rdata = m_pin;
        2'd1: m_rdata = m_cmd;
        2'd2: begin m_rdata = m_stat; m_stat[3] = 1; end
        default: begin
          left = m_cnt - m_ptr;
          if (m_cmd[0] && left > 0) begin
            n = (left > 4) ? 4 : left;
            for (int i = 0; i < n; i++) begin
              if (m_sel && m_av && m_ptr < 128) begin bt = rb(m_ptr); m_ptr++; end
              else bt = 8'h00;
              m_data[i*8 +: 8] = bt;
            end
            m_rdata = m_data;
            if (left <= 4) begin m_phase = m_cmd[27] ? 0 : 2; m_drop(); end
          end else m_rdata = m_data;
        end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pin = 0; m_cmd = 0; m_stat = 0; m_data = 0; m_rdata = 0;
      m_phase = 0; m_drop();
    end else m_step();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_req, " model rdata"}, rdata, m_rdata);
      chk({cur_req, " model phase"}, {30'b0, bus_phase}, 32'(m_phase));
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    mon_present = 1; mon_is_dp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_req = "R1";
    rd(2'd2, v); chk("R1 reset status", v, 32'h0);
    chk("R1 reset phase", {30'b0, bus_phase}, 32'd0);

    cur_req = "R8";
    wr(2'd0, 32'h1);
    rd(2'd2, v); chk("R8 pin select status", v, 32'h19);

    cur_req = "R9";
    wr(2'd2, 32'hFF);
    rd(2'd2, v); chk("R9 in-use cleared, others read-only", v, 32'h11);

    cur_req = "R4";
    wr(2'd1, mkcmd(1, 7'h50, 8'd0, 9'd6, 3'b111, 0));
    chk("R4 transfer enters data phase", {30'b0, bus_phase}, 32'd1);

    cur_req = "R6";
    rd(2'd3, v); chk("R6 four packed bytes", v, {rb(3), rb(2), rb(1), rb(0)});

    cur_req = "R7";
    rd(2'd3, v); chk("R7 partial read keeps upper bytes", v, {rb(3), rb(2), rb(5), rb(4)});
    chk("R7 stop type closes to idle", {30'b0, bus_phase}, 32'd0);
    rd(2'd3, v); chk("R7 closed transfer returns stored", v, {rb(3), rb(2), rb(5), rb(4)});

    cur_req = "R3";
    wr(2'd0, 32'h1);
    wr(2'd1, mkcmd(1, 7'h50, 8'd126, 9'd200, 3'b011, 0));
    rd(2'd3, v); chk("R3 R11 index load and ROM end", v, {8'h00, 8'h00, rb(127), rb(126)});
    cur_req = "R11";
    rd(2'd3, v); chk("R11 past end reads zero", v, 32'h0);
    chk("R11 transfer stays open", {30'b0, bus_phase}, 32'd1);

    cur_req = "R5";
    wr(2'd1, mkcmd(0, 7'h00, 8'd0, 9'd0, 3'b100, 0));
    chk("R5 stop returns to idle", {30'b0, bus_phase}, 32'd0);
    rd(2'd2, v); chk("R5 stop clears active", v & 32'h2, 32'h0);

    cur_req = "R2";
    wr(2'd0, 32'h1);
    wr(2'd1, mkcmd(1, 7'h51, 8'd0, 9'd4, 3'b010, 0));
    rd(2'd3, v); chk("R2 other target reads zero", v, 32'h0);
    chk("R7 non-stop type closes to wait", {30'b0, bus_phase}, 32'd2);

    cur_req = "R5";
    wr(2'd1, mkcmd(0, 7'h00, 8'd0, 9'd0, 3'b000, 0));
    wr(2'd1, mkcmd(0, 7'h00, 8'd0, 9'd0, 3'b100, 0));
    chk("R5 stop after no-cycle ignored", {30'b0, bus_phase}, 32'd2);

    cur_req = "R12";
    wr(2'd3, 32'hDEADBEEF);
    rd(2'd3, v); chk("R12 data write ignored", v, 32'h0);

    cur_req = "R8";
    mon_is_dp = 1;
    wr(2'd0, 32'h2);
    rd(2'd2, v); chk("R8 DP sink sets no-ack", v & 32'h17, 32'h15);

    cur_req = "R10";
    wr(2'd1, mkcmd(0, 7'h00, 8'd0, 9'd0, 3'b000, 1));
    wr(2'd1, mkcmd(1, 7'h50, 8'd0, 9'd4, 3'b010, 1));
    chk("R10 command ignored while clear held", {30'b0, bus_phase}, 32'd0);
    wr(2'd1, 32'h0);
    rd(2'd2, v); chk("R10 controller reset status", v, 32'h5);

    cur_req = "R8";
    mon_is_dp = 0;
    wr(2'd0, 32'h0);
    wr(2'd1, mkcmd(1, 7'h50, 8'd0, 9'd4, 3'b010, 0));
    rd(2'd3, v); chk("R8 R11 zero pin select leaves EDID unavailable", v, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule